// File: doc/BRIEF.md
# Convolution Window Gatherer with Per-Position Queues

This block turns a raster stream of feature-map pixels into complete convolution windows, ready for a systolic array that consumes one K×K window per transfer. Every pixel of an F×F map is taken once, in row-major order, and copied into each window position that uses it. Pixels are never re-read, even though neighbouring windows overlap.

Inside there is one small queue for each of the K×K window positions. A counter-driven steering stage works out, for the current pixel coordinate, which positions of which windows take that pixel. It then writes the pixel into each of those queues at the queue's fill level. A window is finished when its bottom-right pixel arrives. All queues then hand their oldest entry out in parallel, and every remaining entry moves one slot toward the head. With no padding, the window count per side is F' = (F-K)/S + 1. Windows leave in row-major order of their top-left corner. After the last pixel of a map, the block wraps to the next map on its own.

Top module: `place_reorder`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is 0, `in_ready` is 1 and `err_ovf` is 0.
- R2: In an output window with top-left index (by, bx), the field at bits [p*W +: W], where p = r*K + c, holds the input pixel at row by*S + r and column bx*S + c. Input pixels arrive in row-major order, starting at row 0, column 0.
- R3: `err_ovf` goes to 1 when a pixel is routed to a position queue whose DEPTH slots are all occupied. It then stays 1 until reset. It stays 0 when DEPTH is large enough for the map.
- R4: `in_ready` is 0 whenever `out_valid` is 1. A pixel presented while `in_ready` is 0 is not consumed and leaves no trace in any window.
- R5: `out_valid` is 1 straight after the clock edge that accepts a window's bottom-right pixel. It is 0 before that edge if no other window is pending.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_block` hold their values.
- R7: Exactly F'×F' windows are emitted per map, in row-major order of (by, bx). The next map follows without a reset.
- R8: With S > 1, windows step by S pixels in both directions. Pixels that no window covers (for example the right-most column when (F-K) is odd at S=2) are consumed without effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pixel | input | W | Pixel value, row-major order |
| out_valid | output | 1 | A complete window is on `out_block` |
| out_ready | input | 1 | Downstream takes the window this cycle |
| out_block | output | K*K*W | Window, position p = r*K + c at bits [p*W +: W] |
| err_ovf | output | 1 | Sticky: a position queue overflowed |

## Verification
A window becomes visible one edge after its bottom-right pixel is accepted, since the only register on that path is the queue write. The bench therefore checks `out_valid` at the falling edge that follows each accepting rising edge. A pop takes effect at the edge where `out_valid` and `out_ready` are both high. Window contents are compared at the falling edge just before that handshake edge, and the absence of a window is checked at the falling edge after it. Held windows are re-sampled at every falling edge of the stall. The overflow flag is observed after the stream ends and again several cycles later.

// File: rtl/place_reorder_pkg.sv
package place_reorder_pkg;

    localparam int CW = 16;

    typedef struct packed {
        logic [CW-1:0] row;
        logic [CW-1:0] col;
    } pos_t;

    typedef enum logic [1:0] {
        BUF_IDLE  = 2'd0,
        BUF_WRITE = 2'd1,
        BUF_POP   = 2'd2
    } buf_op_e;

    function automatic int out_dim(input int f, input int k, input int s);
        return (f - k) / s + 1;
    endfunction

    // True when a coordinate lands on window offset 'off' of some window
    function automatic logic place_hit(input int coord, input int off,
                                       input int s, input int fo);
        if (coord < off) return 1'b0;
        if (((coord - off) % s) != 0) return 1'b0;
        return ((coord - off) / s) < fo;
    endfunction

endpackage

// File: rtl/place_reorder_arrange.sv
module place_reorder_arrange
    import place_reorder_pkg::*;
#(
    parameter int F = 8,
    parameter int K = 3,
    parameter int S = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [K*K-1:0] need
);
    localparam int FO = out_dim(F, K, S);
    localparam logic [CW-1:0] LAST = CW'(F - 1);

    pos_t pos_q;
    logic [K-1:0] row_hit;
    logic [K-1:0] col_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (adv) begin
            if (pos_q.col == LAST) begin
                pos_q.col <= '0;
                pos_q.row <= (pos_q.row == LAST) ? '0 : pos_q.row + 1'b1;
            end else begin
                pos_q.col <= pos_q.col + 1'b1;
            end
        end
    end

    // Row and column membership are decided separately, then combined
    for (genvar g = 0; g < K; g++) begin : g_axis
        assign row_hit[g] = place_hit(int'(pos_q.row), g, S, FO);
        assign col_hit[g] = place_hit(int'(pos_q.col), g, S, FO);
    end

    for (genvar r = 0; r < K; r++) begin : g_row
        for (genvar c = 0; c < K; c++) begin : g_col
            assign need[r*K + c] = row_hit[r] & col_hit[c];
        end
    end

endmodule

// File: rtl/place_reorder_bank.sv
module place_reorder_bank
    import place_reorder_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         nonempty,
    output logic         ovf
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    logic [W-1:0]    bank_q [DEPTH];
    logic [CNTW-1:0] cnt_q;
    buf_op_e         op;

    always_comb begin
        if (pop)                        op = BUF_POP;
        else if (wr && cnt_q != FULL)   op = BUF_WRITE;
        else                            op = BUF_IDLE;
    end

    assign ovf      = wr && !pop && (cnt_q == FULL);
    assign head     = bank_q[0];
    assign nonempty = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (op)
                BUF_WRITE: cnt_q <= cnt_q + 1'b1;
                BUF_POP:   cnt_q <= cnt_q - 1'b1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    // Data slots carry no reset; occupancy is tracked by cnt_q alone
    always_ff @(posedge clk) begin
        case (op)
            BUF_WRITE: bank_q[cnt_q[AW-1:0]] <= wdata;
            BUF_POP: begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    bank_q[i] <= bank_q[i+1];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/place_reorder.sv
module place_reorder
    import place_reorder_pkg::*;
#(
    parameter int F     = 8,
    parameter int K     = 3,
    parameter int S     = 1,
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W-1:0]   in_pixel,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [K*K*W-1:0] out_block,
    output logic           err_ovf
);
    localparam int NP = K * K;

    logic          accept;
    logic          pop;
    logic [NP-1:0] need;
    logic [NP-1:0] nonempty;
    logic [NP-1:0] ovf_vec;
    logic          err_q;

    assign accept = in_valid && in_ready;
    assign pop    = out_valid && out_ready;

    // Every position queue holds an entry for the oldest finished window
    assign out_valid = &nonempty;
    assign in_ready  = !out_valid;
    assign err_ovf   = err_q;

    place_reorder_arrange #(
        .F(F), .K(K), .S(S)
    ) u_arrange (
        .clk  (clk),
        .rst  (rst),
        .adv  (accept),
        .need (need)
    );

    for (genvar p = 0; p < NP; p++) begin : g_place
        place_reorder_bank #(
            .W(W), .DEPTH(DEPTH)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr       (accept && need[p]),
            .pop      (pop),
            .wdata    (in_pixel),
            .head     (out_block[p*W +: W]),
            .nonempty (nonempty[p]),
            .ovf      (ovf_vec[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           err_q <= 1'b0;
        else if (|ovf_vec) err_q <= 1'b1;
    end

endmodule

// File: rtl/place_reorder_chk.sv
module place_reorder_chk #(
    parameter int K = 3,
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [K*K*W-1:0] out_block,
    input logic             err_ovf
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready && !err_ovf));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_ovf |=> err_ovf);

    a_r4_stall_until_pop: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> !in_ready);

    a_r5_rise_after_input: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    a_r6_hold_window: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));

endmodule

bind place_reorder place_reorder_chk #(
    .K(K), .W(W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block),
    .err_ovf   (err_ovf)
);

// File: tb/place_reorder_bench.sv
module place_reorder_bench;
    localparam int W  = 8;
    localparam int K  = 3;
    localparam int NP = K * K;
    localparam int FA = 8, SA = 1, FOA = 6;
    localparam int FB = 7, SB = 2, FOB = 3;
    localparam int FC = 6;

    // Table rows: [15:8] map seed, [7:0] out_ready pattern per cycle
    localparam logic [15:0] PATS [3] = '{16'h01FF, 16'h02A6, 16'h0311};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic a_iv = 0, a_ir, a_ov, a_or = 0, a_err;
    logic [W-1:0] a_px = '0;
    logic [NP*W-1:0] a_blk;
    logic b_iv = 0, b_ir, b_ov, b_or = 1, b_err;
    logic [W-1:0] b_px = '0;
    logic [NP*W-1:0] b_blk;
    logic c_iv = 0, c_ir, c_ov, c_or = 1, c_err;
    logic [W-1:0] c_px = '0;
    logic [NP*W-1:0] c_blk;

    place_reorder #(.F(FA), .K(K), .S(SA), .W(W), .DEPTH(16)) u_place_reorder (
        .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir), .in_pixel(a_px),
        .out_valid(a_ov), .out_ready(a_or), .out_block(a_blk), .err_ovf(a_err));

    place_reorder #(.F(FB), .K(K), .S(SB), .W(W), .DEPTH(8)) u_place_reorder_s2 (
        .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir), .in_pixel(b_px),
        .out_valid(b_ov), .out_ready(b_or), .out_block(b_blk), .err_ovf(b_err));

    place_reorder #(.F(FC), .K(K), .S(1), .W(W), .DEPTH(2)) u_place_reorder_ovf (
        .clk(clk), .rst(rst), .in_valid(c_iv), .in_ready(c_ir), .in_pixel(c_px),
        .out_valid(c_ov), .out_ready(c_or), .out_block(c_blk), .err_ovf(c_err));

    int n_chk = 0;
    int n_fail = 0;
    int b_idx = 0;
    logic b_run = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pv(input int f, input int fr, input int y, input int x);
        return W'(fr * 37 + y * f + x + 1);
    endfunction

    function automatic logic [NP*W-1:0] exp_blk(input int f, input int s, input int fr,
                                                input int by, input int bx);
        logic [NP*W-1:0] v;
        v = '0;
        for (int r = 0; r < K; r++)
            for (int c = 0; c < K; c++)
                v[(r*K + c)*W +: W] = pv(f, fr, by*s + r, bx*s + c);
        return v;
    endfunction

    task automatic send_a(input int fr, input int idx);
        bit hs;
        forever begin
            @(negedge clk);
            a_iv = 1'b1;
            a_px = pv(FA, fr, idx / FA, idx % FA);
            hs = a_ir;
            @(posedge clk);
            if (hs) break;
        end
    endtask

    task automatic send_b(input int fr, input int idx);
        bit hs;
        forever begin
            @(negedge clk);
            b_iv = 1'b1;
            b_px = pv(FB, fr, idx / FB, idx % FB);
            hs = b_ir;
            @(posedge clk);
            if (hs) break;
        end
    endtask

    task automatic send_c(input int idx);
        bit hs;
        forever begin
            @(negedge clk);
            c_iv = 1'b1;
            c_px = W'(idx);
            hs = c_ir;
            @(posedge clk);
            if (hs) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        a_iv = 0; b_iv = 0; c_iv = 0; a_or = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!a_ov && a_ir && !a_err, "R1", "valid/ready/err after reset",
            {a_ov, a_ir, a_err}, 3'b010);
    endtask

    task automatic drive_a(input int fr);
        for (int i = 0; i < FA * FA; i++) send_a(fr, i);
        @(negedge clk);
        a_iv = 1'b0;
    endtask

    task automatic collect_a(input int fr, input logic [7:0] mask);
        int idx;
        int cyc;
        idx = 0;
        cyc = 0;
        while (idx < FOA * FOA) begin
            @(negedge clk);
            a_or = mask[cyc % 8];
            cyc++;
            if (a_ov && a_or) begin
                chk(a_blk == exp_blk(FA, SA, fr, idx / FOA, idx % FOA),
                    "R2", "window contents in row-major order (R7)",
                    a_blk, exp_blk(FA, SA, fr, idx / FOA, idx % FOA));
                idx++;
            end
        end
    endtask

    // Stride-2 instance: consumer always ready
    always @(negedge clk) begin
        if (b_run && b_ov) begin
            chk(b_blk == exp_blk(FB, SB, 5, b_idx / FOB, b_idx % FOB),
                "R8", "stride-2 window contents", b_blk,
                exp_blk(FB, SB, 5, b_idx / FOB, b_idx % FOB));
            b_idx++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NP*W-1:0] held;
        do_reset();

        // R5: the window appears right after its bottom-right pixel
        for (int i = 0; i < 2 * FA + 3; i++) begin
            send_a(0, i);
            @(negedge clk);
            a_iv = 1'b0;
            chk(a_ov == (i == 2 * FA + 2), "R5", "out_valid after pixel", a_ov, (i == 2 * FA + 2));
        end
        chk(!a_ir, "R4", "in_ready low while window pending", a_ir, 0);
        held = a_blk;
        chk(held == exp_blk(FA, SA, 0, 0, 0), "R2", "first window", held, exp_blk(FA, SA, 0, 0, 0));

        // R6 and R4: stall with a bogus pixel offered
        for (int k = 0; k < 3; k++) begin
            a_iv = 1'b1;
            a_px = 8'hEE;
            @(negedge clk);
            chk(a_ov && a_blk == held, "R6", "window held under stall", a_blk, held);
            chk(!a_ir, "R4", "in_ready stays low under stall", a_ir, 0);
        end
        a_iv = 1'b0;
        a_or = 1'b1;
        @(negedge clk);
        a_or = 1'b0;
        chk(!a_ov && a_ir, "R4", "pop frees input", {a_ov, a_ir}, 2'b01);
        send_a(0, 2 * FA + 3);
        @(negedge clk);
        a_iv = 1'b0;
        chk(a_ov && a_blk == exp_blk(FA, SA, 0, 0, 1), "R4",
            "stalled pixel not consumed", a_blk, exp_blk(FA, SA, 0, 0, 1));

        do_reset();

        // Table walk: back-to-back maps with varied consumer patterns
        for (int t = 0; t < 3; t++) begin
            fork
                drive_a(int'(PATS[t][15:8]));
                collect_a(int'(PATS[t][15:8]), PATS[t][7:0]);
            join
            @(negedge clk);
            a_or = 1'b0;
            chk(!a_ov && a_ir, "R7", "no extra window after map", {a_ov, a_ir}, 2'b01);
        end
        chk(!a_err, "R3", "no overflow with adequate depth", a_err, 0);

        // Stride-2 map
        b_run = 1'b1;
        for (int i = 0; i < FB * FB; i++) send_b(5, i);
        @(negedge clk);
        b_iv = 1'b0;
        repeat (4) @(negedge clk);
        chk(b_idx == FOB * FOB, "R7", "stride-2 window count", b_idx, FOB * FOB);
        chk(!b_ov && b_ir, "R8", "uncovered pixels leave nothing", {b_ov, b_ir}, 2'b01);
        chk(!b_err, "R3", "stride-2 no overflow", b_err, 0);
        b_run = 1'b0;

        // Undersized queues
        for (int i = 0; i < FC * FC; i++) send_c(i);
        @(negedge clk);
        c_iv = 1'b0;
        chk(c_err, "R3", "overflow flagged", c_err, 1);
        repeat (5) @(negedge clk);
        chk(c_err, "R3", "overflow flag sticky", c_err, 1);
        do_reset();
        chk(!c_err && !c_ov && c_ir, "R1", "overflow cleared by reset", {c_err, c_ov, c_ir}, 3'b001);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule